// File: doc/BRIEF.md
# Port-Write Message Capture Unit

This block takes maintenance port-write messages from a link model and keeps one of them in a single-slot capture buffer. A message arrives as a fixed run of beats on a valid/data input. Software reaches the unit through a small word-addressed register interface. That interface holds a mode register, a status register, two queue base address registers and a read window onto the captured words.

After the last beat of a message lands, the slot is marked full and an interrupt flag is raised. Any later message is dropped whole, and the drop is recorded, until software issues a clear-queue command through the mode register. A transaction-error input sets an error flag. Software can clear that flag only while the unit is disabled, so the sequence is: disable, clear, re-enable. The interrupt line combines the two interrupt flags with their enables.

Top module: `pw_capture_unit`

## Requirements
- R1: After reset, the mode, status and both base registers read 0, and `irq` is 0.
- R2: While enabled (mode bit 0) and the slot is empty, a message of 16 beats is stored. After the 16th beat, status bit 20 (slot full) and status bit 4 (capture interrupt flag) read 1. Word i reads back at address 16+i.
- R3: Status bit 2 (busy) reads 1 while an accepted message is partly received, and reads 0 otherwise.
- R4: A message whose first beat arrives while the slot is full is dropped whole. The stored words stay unchanged, and status bit 3 (discarded) sets.
- R5: Writing the mode register (address 0) with bit 1 set empties the slot, so status bit 20 clears. Bit 1 always reads 0. Bits 0, 5, 8 and 20 read back as written.
- R6: Status bits 3 and 4 clear when 1 is written to them at address 1. Writing 0 leaves them unchanged.
- R7: A pulse on `link_err` while enabled sets status bit 7. Writing 1 to bit 7 clears it only if mode bit 0 is 0 at the time of the write.
- R8: `irq` equals (status bit 4 AND mode bit 8) OR (status bit 7 AND mode bit 5).
- R9: While disabled, beats are ignored and set no flag. Disabling in mid-message abandons the partial message, and the next message after re-enabling starts from beat 0.
- R10: The base address registers (addresses 2 and 3) accept writes only while mode bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_valid | input | 1 | One message beat is present |
| link_data | input | 32 | Beat payload |
| link_err | input | 1 | Transaction error pulse from the link |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| irq | output | 1 | Interrupt request |

## Verification
A beat counter that has slipped would show up within one message. The full flag would then rise on the wrong beat, and the words read back at addresses 16 to 31 would be shifted. A full flag that is stuck or released by mistake would show on the next message: either it is wrongly captured, overwriting the stored words, or it is wrongly dropped, setting bit 3. A wrong flag or enable would show on `irq` one cycle after the event that caused it.

// File: rtl/pwc_pkg.sv
// Package: shared widths, register word addresses and bit positions for the
// port-write capture unit. Assumes a word-addressed register space.
package pwc_pkg;
    localparam int WORD_W    = 32;
    localparam int MSG_WORDS = 16;
    localparam int ADDR_W    = 5;

    localparam logic [ADDR_W-1:0] A_MODE    = 5'd0;
    localparam logic [ADDR_W-1:0] A_STATUS  = 5'd1;
    localparam logic [ADDR_W-1:0] A_BASE_HI = 5'd2;
    localparam logic [ADDR_W-1:0] A_BASE_LO = 5'd3;
    localparam logic [ADDR_W-1:0] A_BUF     = 5'd16;

    // mode bits
    localparam int M_EN   = 0;
    localparam int M_CQ   = 1;
    localparam int M_EIE  = 5;
    localparam int M_QFIE = 8;
    localparam int M_SEN  = 20;
    // status bits
    localparam int S_BUSY = 2;
    localparam int S_DISC = 3;
    localparam int S_QFI  = 4;
    localparam int S_TE   = 7;
    localparam int S_QF   = 20;
endpackage

// File: rtl/pwc_mode_regs.sv
// Mode and base-address registers. Clear-queue is emitted as a one-cycle
// pulse and never stored. Base registers are writable only while disabled.
module pwc_mode_regs
    import pwc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic              en,
    output logic              eie,
    output logic              qfie,
    output logic              cq_pulse,
    output logic [WORD_W-1:0] mode_word,
    output logic [WORD_W-1:0] base_hi,
    output logic [WORD_W-1:0] base_lo
);
    logic sen;
    logic wr_mode;

    assign wr_mode  = reg_wr && (reg_addr == A_MODE);
    assign cq_pulse = wr_mode && reg_wdata[M_CQ];

    // Mode bit storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0; eie <= 1'b0; qfie <= 1'b0; sen <= 1'b0;
        end else if (wr_mode) begin
            en   <= reg_wdata[M_EN];
            eie  <= reg_wdata[M_EIE];
            qfie <= reg_wdata[M_QFIE];
            sen  <= reg_wdata[M_SEN];
        end
    end

    // Base registers, configuration allowed only while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hi <= '0;
            base_lo <= '0;
        end else if (reg_wr && !en) begin
            if (reg_addr == A_BASE_HI) base_hi <= reg_wdata;
            if (reg_addr == A_BASE_LO) base_lo <= reg_wdata;
        end
    end

    // Readback image of the mode register.
    always_comb begin
        mode_word         = '0;
        mode_word[M_EN]   = en;
        mode_word[M_EIE]  = eie;
        mode_word[M_QFIE] = qfie;
        mode_word[M_SEN]  = sen;
    end
endmodule

// File: rtl/pwc_capture.sv
// Capture slot: counts message beats, stores an accepted message, marks the
// slot full on the last beat and reports a drop on the first beat of a
// message that meets a full slot. Assumes fixed-length messages.
module pwc_capture
    import pwc_pkg::*;
#(
    parameter int N_WORDS = MSG_WORDS,
    parameter int W       = WORD_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic                       beat_valid,
    input  logic [W-1:0]               beat_data,
    input  logic                       cq_pulse,
    input  logic [$clog2(N_WORDS)-1:0] rd_idx,
    output logic [W-1:0]               rd_word,
    output logic                       full,
    output logic                       busy,
    output logic                       done_pulse,
    output logic                       drop_pulse
);
    localparam int IDX_W = $clog2(N_WORDS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_WORDS - 1);

    logic [IDX_W-1:0] idx;
    logic             accepting;
    logic             take;
    logic [W-1:0]     slot [N_WORDS];

    assign take       = en && beat_valid && ((idx == '0) ? !full : accepting);
    assign done_pulse = take && (idx == LAST);
    assign drop_pulse = en && beat_valid && (idx == '0) && full;
    assign busy       = accepting && (idx != '0);
    assign rd_word    = slot[rd_idx];

    // Beat position and accept decision for the current message.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            idx       <= '0;
            accepting <= 1'b0;
        end else if (beat_valid) begin
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
            if (idx == '0) accepting <= !full;
        end
    end

    // Slot occupancy: set on last accepted beat, released by clear-queue.
    always_ff @(posedge clk) begin
        if (!rst_n)          full <= 1'b0;
        else if (done_pulse) full <= 1'b1;
        else if (cq_pulse)   full <= 1'b0;
    end

    // Message word storage, one lane per beat position.
    for (genvar g = 0; g < N_WORDS; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)                          slot[g] <= '0;
            else if (take && idx == IDX_W'(g))   slot[g] <= beat_data;
        end
    end
endmodule

// File: rtl/pwc_status.sv
// Status flags and interrupt. Flags are write-1-to-clear; the error flag
// clears only while the unit is disabled.
module pwc_status
    import pwc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              eie,
    input  logic              qfie,
    input  logic              done_pulse,
    input  logic              drop_pulse,
    input  logic              link_err,
    input  logic              wr_status,
    input  logic [WORD_W-1:0] wdata,
    output logic              qfi,
    output logic              disc,
    output logic              te,
    output logic              irq
);
    // Capture interrupt flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                      qfi <= 1'b0;
        else if (done_pulse)             qfi <= 1'b1;
        else if (wr_status && wdata[S_QFI]) qfi <= 1'b0;
    end

    // Discarded flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                       disc <= 1'b0;
        else if (drop_pulse)              disc <= 1'b1;
        else if (wr_status && wdata[S_DISC]) disc <= 1'b0;
    end

    // Transaction error flag, cleared only with the unit disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 te <= 1'b0;
        else if (en && link_err)                    te <= 1'b1;
        else if (wr_status && wdata[S_TE] && !en)   te <= 1'b0;
    end

    // Interrupt request.
    assign irq = (qfi && qfie) || (te && eie);
endmodule

// File: rtl/pw_capture_unit.sv
// Top: port-write capture unit. Wires the mode registers, capture slot and
// status flags, and decodes register reads. Reads are combinational.
module pw_capture_unit
    import pwc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_valid,
    input  logic [WORD_W-1:0] link_data,
    input  logic              link_err,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int IDX_W = $clog2(MSG_WORDS);

    logic en, eie, qfie, cq_pulse;
    logic [WORD_W-1:0] mode_word, base_hi, base_lo, buf_word, status_word;
    logic full, busy, done_pulse, drop_pulse;
    logic qfi, disc, te;

    pwc_mode_regs u_mode (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .en(en), .eie(eie), .qfie(qfie),
        .cq_pulse(cq_pulse), .mode_word(mode_word),
        .base_hi(base_hi), .base_lo(base_lo)
    );

    pwc_capture #(.N_WORDS(MSG_WORDS), .W(WORD_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .en(en), .beat_valid(link_valid),
        .beat_data(link_data), .cq_pulse(cq_pulse),
        .rd_idx(reg_addr[IDX_W-1:0]), .rd_word(buf_word), .full(full),
        .busy(busy), .done_pulse(done_pulse), .drop_pulse(drop_pulse)
    );

    pwc_status u_stat (
        .clk(clk), .rst_n(rst_n), .en(en), .eie(eie), .qfie(qfie),
        .done_pulse(done_pulse), .drop_pulse(drop_pulse), .link_err(link_err),
        .wr_status(reg_wr && reg_addr == A_STATUS), .wdata(reg_wdata),
        .qfi(qfi), .disc(disc), .te(te), .irq(irq)
    );

    // Status readback image.
    always_comb begin
        status_word         = '0;
        status_word[S_BUSY] = busy;
        status_word[S_DISC] = disc;
        status_word[S_QFI]  = qfi;
        status_word[S_TE]   = te;
        status_word[S_QF]   = full;
    end

    // Register read decode.
    always_comb begin
        if (reg_addr >= A_BUF)             reg_rdata = buf_word;
        else if (reg_addr == A_MODE)       reg_rdata = mode_word;
        else if (reg_addr == A_STATUS)     reg_rdata = status_word;
        else if (reg_addr == A_BASE_HI)    reg_rdata = base_hi;
        else if (reg_addr == A_BASE_LO)    reg_rdata = base_lo;
        else                               reg_rdata = '0;
    end
endmodule

// File: rtl/pw_capture_unit_checker.sv
// Checker for pw_capture_unit, attached by bind. Relates flags driven by
// separate submodules across clock cycles.
module pw_capture_unit_checker (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic full,
    input logic busy,
    input logic qfi,
    input logic te,
    input logic cq_pulse
);
    // R4: a full slot stays full unless clear-queue is written
    a_r4_full_held: assert property (@(posedge clk) disable iff (!rst_n)
        full && !cq_pulse |=> full);
    // R7: error flag cannot clear while enabled
    a_r7_te_held: assert property (@(posedge clk) disable iff (!rst_n)
        te && en |=> te);
    // R2: slot becoming full always raises the capture flag
    a_r2_qfi_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> qfi);
    // R3: busy never coexists with a full slot
    a_r3_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && full));
    // R9: no capture completes while disabled
    a_r9_no_fill_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en && !full |=> !full);
endmodule

bind pw_capture_unit pw_capture_unit_checker u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .full(full), .busy(busy),
    .qfi(qfi), .te(te), .cq_pulse(cq_pulse)
);

// File: tb/pw_capture_unit_tb.sv
module pw_capture_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_valid = 1'b0;
    logic [31:0] link_data = '0;
    logic        link_err = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_buf [16];
    logic [31:0] seed_v;

    localparam logic [31:0] MODE_ALL = 32'h0010_0121; // en|eie|qfie|sen

    always #10 clk = ~clk;

    pw_capture_unit u_dut (
        .clk(clk), .rst_n(rst_n), .link_valid(link_valid), .link_data(link_data),
        .link_err(link_err), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [31:0] status_exp(bit busy, bit disc, bit qfi, bit te, bit qf);
        return (32'(busy) << 2) | (32'(disc) << 3) | (32'(qfi) << 4) |
               (32'(te) << 7) | (32'(qf) << 20);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_check(string req, logic [4:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic beats(int n, bit store);
        for (int i = 0; i < n; i++) begin
            logic [31:0] w;
            w = $urandom;
            link_valid = 1'b1; link_data = w;
            if (store) exp_buf[i] = w;
            @(negedge clk);
        end
        link_valid = 1'b0;
    endtask

    task automatic beats_from(int start, int n);
        for (int i = start; i < start + n; i++) begin
            logic [31:0] w;
            w = $urandom;
            link_valid = 1'b1; link_data = w; exp_buf[i] = w;
            @(negedge clk);
        end
        link_valid = 1'b0;
    endtask

    task automatic check_buf(string req);
        for (int i = 0; i < 16; i++) rd_check(req, 5'(16 + i), exp_buf[i]);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        seed_v = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_check("R1", 0, 0); rd_check("R1", 1, 0);
        rd_check("R1", 2, 0); rd_check("R1", 3, 0);
        check("R1", 32'(irq), 0);
        // R10 base writes while disabled
        wr(2, 32'h0000_00AB); wr(3, 32'h1234_5000);
        rd_check("R10", 2, 32'h0000_00AB); rd_check("R10", 3, 32'h1234_5000);
        // R5 enable, readback, cq reads 0
        wr(0, MODE_ALL | 32'h2);
        rd_check("R5", 0, MODE_ALL);
        // R10 base write while enabled ignored
        wr(3, 32'hFFFF_FFFF);
        rd_check("R10", 3, 32'h1234_5000);
        // R3 busy mid message, R2 capture
        beats(8, 1);
        rd_check("R3", 1, status_exp(1, 0, 0, 0, 0));
        beats_from(8, 8);
        rd_check("R2", 1, status_exp(0, 0, 1, 0, 1));
        check("R8", 32'(irq), 1);
        check_buf("R2");
        // R4 drop while full
        beats(16, 0);
        rd_check("R4", 1, status_exp(0, 1, 1, 0, 1));
        check_buf("R4");
        // R6 W1C
        wr(1, 0);
        rd_check("R6", 1, status_exp(0, 1, 1, 0, 1));
        wr(1, 32'h10);
        rd_check("R6", 1, status_exp(0, 1, 0, 0, 1));
        check("R8", 32'(irq), 0);
        wr(1, 32'h08);
        rd_check("R6", 1, status_exp(0, 0, 0, 0, 1));
        // R5 clear-queue releases slot
        wr(0, MODE_ALL | 32'h2);
        rd_check("R5", 1, 0);
        rd_check("R5", 0, MODE_ALL);
        // R7 transaction error
        link_err = 1'b1; @(negedge clk); link_err = 1'b0;
        rd_check("R7", 1, status_exp(0, 0, 0, 1, 0));
        check("R8", 32'(irq), 1);
        wr(1, 32'h80);
        rd_check("R7", 1, status_exp(0, 0, 0, 1, 0));
        wr(0, MODE_ALL & ~32'h1);
        wr(1, 32'h80);
        rd_check("R7", 1, 0);
        check("R8", 32'(irq), 0);
        // R8 eie off: error sets flag? no, disabled; enable without eie
        wr(0, 32'h1);
        link_err = 1'b1; @(negedge clk); link_err = 1'b0;
        check("R8", 32'(irq), 0);
        rd_check("R7", 1, status_exp(0, 0, 0, 1, 0));
        wr(0, 32'h0); wr(1, 32'h80);
        // R9 ignored while disabled
        beats(16, 0);
        rd_check("R9", 1, 0);
        // R9 partial abandoned
        wr(0, MODE_ALL);
        beats(5, 0);
        wr(0, MODE_ALL & ~32'h1);
        wr(0, MODE_ALL);
        beats(16, 1);
        rd_check("R9", 1, status_exp(0, 0, 1, 0, 1));
        check_buf("R9");
        // R2 random rounds
        for (int r = 0; r < 6; r++) begin
            wr(1, 32'h98);
            wr(0, MODE_ALL | 32'h2);
            beats(16, 1);
            repeat ($urandom_range(0, 3)) @(negedge clk);
            rd_check("R2", 1, status_exp(0, 0, 1, 0, 1));
            check_buf("R2");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule